// File: doc/BRIEF.md
# Decaying Frequent-Value Dictionary

This block keeps a small table of frequently seen data words for a compressed level-1 data cache. A line fill presents each of its words on the lookup port. A word that is already in the table returns its index so the cache can store the short index instead of the full word. A word that is not in the table is written into a free slot if one exists, and that index is returned in the same cycle. A read of a compressed word uses the decode port to turn an index back into its value. When a cache line is accessed, the touch port receives the indices of that line's other compressed words in one cycle, which keeps those entries alive without reading them.

Entries are never evicted on demand. Each entry has a small idle counter. A shared prescaler advances this counter once per tick period, and any access to the entry clears it. An entry that stays idle for the full decay interval is marked free, but its stored value is kept. Cache lines decay over the same interval, so a slot is only reused once no live line can still refer to it. New words take the lowest-numbered free slot, which a combinational priority circuit selects.

Top module: `fv_decay_dict`

## Requirements
- R1: After reset every entry is free. A lookup of any word, including zero, misses, and the first inserted word lands at index 0.
- R2: A lookup of a word held by a live entry raises `lk_hit` in the same cycle, with `lk_idx` equal to that entry's index.
- R3: A lookup miss while at least one entry is free raises `lk_ins` in the same cycle, with `lk_idx` equal to the lowest-numbered free entry. From the next cycle that entry is live, holds the word and has a cleared idle count.
- R4: A lookup miss while every entry is live leaves `lk_ins` low and changes no entry. A live entry never becomes free except through decay.
- R5: `dec_value` shows, combinationally, the value stored at `dec_idx`, whether that entry is live or free.
- R6: A tick occurs on every TICK_PERIOD-th clock edge after reset. Each tick raises the idle count of every live entry that is not accessed. A live entry whose count is already at its maximum (2^CNT_W - 1) becomes free on a tick, so an untouched entry becomes free 2^CNT_W ticks after its last access.
- R7: A lookup hit, a decode with `dec_valid` high, or a touch lane naming a live entry clears that entry's idle count.
- R8: The touch port takes TOUCH_N indices in one cycle. Lane t uses bits [t*IDX_W +: IDX_W] of `touch_idx` and is enabled by `touch_mask[t]`. A lane whose mask bit is low has no effect.
- R9: A free entry never reports a hit, even when its stale value equals the word looked up. Looking that word up again inserts it into the lowest free entry.
- R10: When an access and a tick affect the same entry in the same cycle, the access wins and the idle count becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_word | input | VAL_W | Word to look up |
| lk_hit | output | 1 | Word found in a live entry |
| lk_ins | output | 1 | Word missed and is being written into a free entry |
| lk_idx | output | IDX_W | Index of the hit entry, or of the entry being filled |
| dec_valid | input | 1 | Decode request present (refreshes the entry) |
| dec_idx | input | IDX_W | Index to decode |
| dec_value | output | VAL_W | Value stored at `dec_idx` |
| touch_mask | input | TOUCH_N | Per-lane enable for the touch port |
| touch_idx | input | TOUCH_N*IDX_W | Packed touch indices, lane t in bits [t*IDX_W +: IDX_W] |

## Verification
The hardest cases to reach are an entry that decays while another entry with the same stale value is still live, and an access that lands exactly on a tick edge while the entry's count is at its maximum. The bench uses a short tick period so that decay happens within tens of cycles. It fills the table and then refreshes only some entries through touches and decodes, so that holes open at known indices. The bench then runs a long pseudo-random phase over a small pool of words with idle gaps, and a behavioural model compares every output on every cycle. That phase makes hits on tick edges, refills of decayed slots and full-table misses occur many times.

// File: rtl/fvd_pkg.sv
package fvd_pkg;
    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_HIT  = 2'd1,
        LK_FILL = 2'd2,
        LK_FULL = 2'd3
    } lk_kind_e;
endpackage

// File: rtl/fvd_tick_gen.sv
module fvd_tick_gen #(
    parameter int PERIOD = 2048
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] pre_d, pre_q;

    always_comb begin
        tick  = (pre_q == CW'(PERIOD - 1));
        pre_d = tick ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/fvd_match.sv
module fvd_match #(
    parameter int N     = 32,
    parameter int VAL_W = 32
) (
    input  logic [VAL_W-1:0]   word,
    input  logic [N*VAL_W-1:0] vals,
    input  logic [N-1:0]       live,
    output logic [N-1:0]       hit_vec
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = live[i] && (vals[i*VAL_W +: VAL_W] == word);
    end
endmodule

// File: rtl/fvd_prio.sv
module fvd_prio #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/fv_decay_dict.sv
module fv_decay_dict #(
    parameter int IDX_W       = 5,
    parameter int VAL_W       = 32,
    parameter int CNT_W       = 2,
    parameter int TICK_PERIOD = 2048,
    parameter int TOUCH_N     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [VAL_W-1:0]         lk_word,
    output logic                     lk_hit,
    output logic                     lk_ins,
    output logic [IDX_W-1:0]         lk_idx,
    input  logic                     dec_valid,
    input  logic [IDX_W-1:0]         dec_idx,
    output logic [VAL_W-1:0]         dec_value,
    input  logic [TOUCH_N-1:0]       touch_mask,
    input  logic [TOUCH_N*IDX_W-1:0] touch_idx
);
    import fvd_pkg::*;

    localparam int N = 1 << IDX_W;
    localparam logic [CNT_W-1:0] AGE_MAX = '1;

    typedef struct packed {
        logic             live;
        logic [CNT_W-1:0] age;
        logic [VAL_W-1:0] val;
    } ent_t;

    ent_t [N-1:0] ent_d, ent_q;

    logic               tick;
    logic [N-1:0]       live_vec;
    logic [N*VAL_W-1:0] val_flat;
    logic [N*CNT_W-1:0] age_flat;
    logic [N-1:0]       hit_vec;
    logic               any_hit, any_free;
    logic [IDX_W-1:0]   hit_idx, free_idx;
    logic [N-1:0]       acc_vec;
    lk_kind_e           kind;

    fvd_tick_gen #(.PERIOD(TICK_PERIOD)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    always_comb begin
        for (int i = 0; i < N; i++) begin
            live_vec[i]                = ent_q[i].live;
            val_flat[i*VAL_W +: VAL_W] = ent_q[i].val;
            age_flat[i*CNT_W +: CNT_W] = ent_q[i].age;
        end
    end

    fvd_match #(.N(N), .VAL_W(VAL_W)) u_match (
        .word   (lk_word),
        .vals   (val_flat),
        .live   (live_vec),
        .hit_vec(hit_vec)
    );

    fvd_prio #(.N(N), .IDX_W(IDX_W)) u_hit_enc (
        .req  (hit_vec),
        .found(any_hit),
        .idx  (hit_idx)
    );

    fvd_prio #(.N(N), .IDX_W(IDX_W)) u_free_enc (
        .req  (~live_vec),
        .found(any_free),
        .idx  (free_idx)
    );

    always_comb begin
        if (!lk_valid)     kind = LK_IDLE;
        else if (any_hit)  kind = LK_HIT;
        else if (any_free) kind = LK_FILL;
        else               kind = LK_FULL;
        lk_hit    = (kind == LK_HIT);
        lk_ins    = (kind == LK_FILL);
        lk_idx    = any_hit ? hit_idx : free_idx;
        dec_value = ent_q[dec_idx].val;
    end

    // accesses that refresh an entry this cycle
    always_comb begin
        acc_vec = '0;
        if (kind == LK_HIT) acc_vec[hit_idx] = 1'b1;
        if (dec_valid)      acc_vec[dec_idx] = 1'b1;
        for (int t = 0; t < TOUCH_N; t++) begin
            if (touch_mask[t]) acc_vec[touch_idx[t*IDX_W +: IDX_W]] = 1'b1;
        end
    end

    always_comb begin
        ent_d = ent_q;
        for (int i = 0; i < N; i++) begin
            if (kind == LK_FILL && free_idx == IDX_W'(i)) begin
                ent_d[i].live = 1'b1;
                ent_d[i].age  = '0;
                ent_d[i].val  = lk_word;
            end else if (ent_q[i].live) begin
                if (acc_vec[i]) begin
                    ent_d[i].age = '0;
                end else if (tick) begin
                    if (ent_q[i].age == AGE_MAX) ent_d[i].live = 1'b0;
                    else                         ent_d[i].age  = ent_q[i].age + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end
endmodule

// File: rtl/fvd_chk.sv
module fvd_chk #(
    parameter int IDX_W = 5,
    parameter int CNT_W = 2,
    parameter int N     = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_hit,
    input logic             lk_ins,
    input logic [IDX_W-1:0] lk_idx,
    input logic [N-1:0]     live_vec,
    input logic [N*CNT_W-1:0] age_flat,
    input logic             tick
);
    localparam logic [N*CNT_W-1:0] AGE_MASK = {{(N*CNT_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    // R9
    dead_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_hit |-> live_vec[lk_idx]);

    // R3
    fill_target_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_ins |-> !live_vec[lk_idx] && !lk_hit);

    // R3
    fill_goes_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_ins |=> live_vec[$past(lk_idx)]);

    // R4
    full_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !lk_hit && (&live_vec) |-> !lk_ins);

    // R4
    no_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $countones(live_vec) >= $past($countones(live_vec)));

    // R10
    hit_clears_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_hit |=> ((age_flat >> ($past(lk_idx) * CNT_W)) & AGE_MASK) == '0);
endmodule

bind fv_decay_dict fvd_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W), .N(1 << IDX_W)) u_fvd_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_valid(lk_valid),
    .lk_hit  (lk_hit),
    .lk_ins  (lk_ins),
    .lk_idx  (lk_idx),
    .live_vec(live_vec),
    .age_flat(age_flat),
    .tick    (tick)
);

// File: tb/fv_decay_dict_bench.sv
module fv_decay_dict_bench;
    localparam int IDX_W = 4;
    localparam int VAL_W = 32;
    localparam int CNT_W = 2;
    localparam int P     = 8;
    localparam int TN    = 4;
    localparam int N     = 1 << IDX_W;
    localparam int AMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic [VAL_W-1:0] lk_word = '0;
    logic lk_hit, lk_ins;
    logic [IDX_W-1:0] lk_idx;
    logic dec_valid = 1'b0;
    logic [IDX_W-1:0] dec_idx = '0;
    logic [VAL_W-1:0] dec_value;
    logic [TN-1:0] touch_mask = '0;
    logic [TN*IDX_W-1:0] touch_idx = '0;

    always #4 clk = ~clk;

    fv_decay_dict #(.IDX_W(IDX_W), .VAL_W(VAL_W), .CNT_W(CNT_W),
                    .TICK_PERIOD(P), .TOUCH_N(TN)) u_fv_decay_dict (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_word(lk_word),
        .lk_hit(lk_hit), .lk_ins(lk_ins), .lk_idx(lk_idx),
        .dec_valid(dec_valid), .dec_idx(dec_idx), .dec_value(dec_value),
        .touch_mask(touch_mask), .touch_idx(touch_idx)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // behavioural reference
    logic [VAL_W-1:0] m_val [N];
    bit               m_live[N];
    int               m_age [N];
    int               edges = 0;

    function automatic void predict(output bit hit, output bit ins, output int idx);
        hit = 0; ins = 0; idx = -1;
        if (!lk_valid) return;
        for (int i = 0; i < N; i++)
            if (m_live[i] && m_val[i] == lk_word && idx < 0) begin hit = 1; idx = i; end
        if (!hit)
            for (int i = 0; i < N; i++)
                if (!m_live[i] && idx < 0) begin ins = 1; idx = i; end
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one clock: compare outputs, then advance the model at the edge
    task automatic step(string tag);
        bit hit, ins; int idx;
        bit acc[N];
        bit tk;
        #1;
        predict(hit, ins, idx);
        check(tag, "lk_hit", lk_hit, hit);
        check(tag, "lk_ins", lk_ins, ins);
        if (hit || ins) check(tag, "lk_idx", lk_idx, idx);
        check(tag, "dec_value", dec_value, m_val[dec_idx]);
        @(posedge clk);
        tk = (edges % P) == (P - 1);
        edges++;
        for (int i = 0; i < N; i++) acc[i] = 0;
        if (hit) acc[idx] = 1;
        if (dec_valid) acc[dec_idx] = 1;
        for (int t = 0; t < TN; t++)
            if (touch_mask[t]) acc[touch_idx[t*IDX_W +: IDX_W]] = 1;
        for (int i = 0; i < N; i++) begin
            if (ins && i == idx) begin
                m_live[i] = 1; m_age[i] = 0; m_val[i] = lk_word;
            end else if (m_live[i]) begin
                if (acc[i]) m_age[i] = 0;
                else if (tk) begin
                    if (m_age[i] == AMAX) m_live[i] = 0;
                    else m_age[i]++;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic idle_in();
        lk_valid = 0; dec_valid = 0; touch_mask = '0;
    endtask

    task automatic look(logic [VAL_W-1:0] w, string tag);
        idle_in(); lk_valid = 1; lk_word = w; step(tag);
    endtask

    task automatic idle(int n, string tag);
        idle_in();
        for (int k = 0; k < n; k++) step(tag);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < N; i++) begin m_val[i] = '0; m_live[i] = 0; m_age[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all free, stale zero never hits, first fill at 0
        idle_in(); lk_valid = 1; lk_word = '0; #1;
        check("R1", "reset hit on zero", lk_hit, 0);
        check("R1", "reset fill index", lk_idx, 0);
        step("R1");
        // R3: fill the whole table, lowest free first
        for (int i = 1; i < N; i++) look(32'hA000_0000 + i, "R3");
        // R4: table full, miss not inserted
        look(32'hDEAD_BEEF, "R4");
        look(32'hDEAD_BEEF, "R4");
        // R2: hits on several entries
        look(32'hA000_0005, "R2");
        look(32'h0000_0000, "R2");
        look(32'hA000_000F, "R2");
        // R5: decode without refresh side-effects checked through later decay
        for (int i = 0; i < N; i += 3) begin
            idle_in(); dec_idx = IDX_W'(i); step("R5");
        end
        // R7/R8: keep even entries alive via touches, entry 3 via decode, lane 3 masked off
        for (int k = 0; k < 60; k++) begin
            idle_in();
            touch_mask = 4'b0111;
            touch_idx[0 +: IDX_W]       = IDX_W'((k % 4) * 2);
            touch_idx[IDX_W +: IDX_W]   = IDX_W'((k % 4) * 2 + 8);
            touch_idx[2*IDX_W +: IDX_W] = 4'd10;
            touch_idx[3*IDX_W +: IDX_W] = 4'd1;
            if (k % 5 == 0) begin dec_valid = 1; dec_idx = 4'd3; end
            step("R8");
        end
        // R6/R9: odd entries decayed; stale value must miss and refill lowest free
        look(32'hA000_0001, "R9");
        look(32'hA000_0007, "R9");
        idle_in(); dec_idx = 4'd5; step("R5");
        look(32'hA000_0006, "R2");
        look(32'hA000_0003, "R7");
        // R6: let everything decay then refill
        idle(40, "R6");
        look(32'h1234_5678, "R6");
        // R10: hits on every edge phase including tick edges
        for (int k = 0; k < 3 * P; k++) look(32'h1234_5678, "R10");

        // mixed pseudo-random phase over a small word pool
        lf = 16'hACE1;
        for (int k = 0; k < 4000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            idle_in();
            if (lf[0]) begin
                lk_valid = 1;
                lk_word  = 32'h0000_1000 + (lf[7:3] % 24);
            end
            if (lf[8] && lf[9]) begin dec_valid = 1; dec_idx = lf[13:10]; end
            touch_mask = lf[2] ? {lf[11], lf[6], 2'b00} : '0;
            touch_idx  = {lf[15:12], lf[11:8], lf[7:4], lf[3:0]};
            step("R3 R4 R6 R7 R10 mixed");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule